// File: doc/BRIEF.md
# Hit Readout Buffer with Data-Ready Modes

This block sits between the formatter of a time digitizer and the register read port of a host. The formatter pushes 32-bit words (headers, converted times and end-of-block words) into an on-chip first-in first-out store. The host takes one word per read strobe. A data-ready flag tells the host when to read. Its meaning is chosen by a mode input: the store holds anything, the store has filled up to a programmed almost-full level, or at least one complete event is stored.

A read of an empty store returns a tagged non-valid word and never stale data. Status outputs report a full store, a sticky overflow caused by a write that had to be dropped, and an illegal mode combination (event-based data-ready while the formatter runs in continuous storage). A global clear empties the store, zeroes the complete-event counter and clears the overflow flag.

Top module: `hit_readout_buf`

## Requirements
- R1: Words read come out in the order they were written. Each word keeps all 32 bits. `rd_word` shows the word one clock edge after the edge that samples `rd_strobe`.
- R2: With `ready_mode` = 2'b00 (not-empty), `data_ready` is high exactly when at least one word is stored. It is updated at the same edge that changes the occupancy.
- R3: With `ready_mode` = 2'b01 (almost-full), `data_ready` is high exactly when the occupancy is greater than or equal to `af_level`.
- R4: Bits [22:21] of a word give its kind: 2'b10 header, 2'b00 datum, 2'b01 end-of-block, 2'b11 non-valid. With `ready_mode` = 2'b10 (event), `data_ready` is high exactly while at least one end-of-block word is stored. An accepted end-of-block write adds one to the event count, and reading an end-of-block word removes one.
- R5: With `ready_mode` = 2'b10 while `cont_mode` is high, or with `ready_mode` = 2'b11, `data_ready` stays low and `mode_err` is high. Otherwise `mode_err` is low.
- R6: A read strobe while the store is empty returns 32'h0060_0000 (bits 22 and 21 set, all others clear) and leaves the occupancy unchanged.
- R7: `buf_full` is high exactly when DEPTH words are stored.
- R8: A write while the store is full is dropped, even if a read happens in the same cycle. The stored words are unchanged, and `overflow_err` goes high and stays high.
- R9: `clr_all` empties the store, zeroes the event count and clears `overflow_err`. A write or read in the same cycle is ignored.
- R10: After reset, `data_ready`, `buf_full`, `overflow_err` and `mode_err` are low, and `rd_word` shows the non-valid word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| clr_all | input | 1 | Global clear of store, event count and overflow flag |
| wr_valid | input | 1 | Formatter write strobe |
| wr_word | input | 32 | Word to store |
| rd_strobe | input | 1 | Host read strobe, one word per cycle |
| rd_word | output | 32 | Word read, or the non-valid word |
| ready_mode | input | 2 | Data-ready mode select |
| af_level | input | 9 | Almost-full occupancy level |
| cont_mode | input | 1 | High while the formatter runs continuous storage |
| data_ready | output | 1 | Data-ready flag, registered |
| buf_full | output | 1 | Store full, registered |
| overflow_err | output | 1 | Sticky dropped-write flag |
| mode_err | output | 1 | Illegal data-ready mode for the formatter setting |

## Verification
A wrong occupancy count shows at the ports within one edge as a wrong `data_ready` in not-empty or almost-full mode. It also shows as a missing or early non-valid word when the host drains the store. A wrong event count shows only in event mode: `data_ready` stays up after the last end-of-block word is read, or stays low after one is written. A corrupted read or write pointer shows as words out of order on the next read. A dropped write that was in fact stored shows as an extra word before the non-valid word at the end of a drain.

// File: rtl/hrb_pkg.sv
package hrb_pkg;
  localparam int WORD_W  = 32;
  localparam int KIND_HI = 22;
  localparam int KIND_LO = 21;

  typedef enum logic [1:0] {
    KIND_DATUM  = 2'b00,
    KIND_EOB    = 2'b01,
    KIND_HEADER = 2'b10,
    KIND_NONVAL = 2'b11
  } word_kind_e;

  typedef enum logic [1:0] {
    DR_NOT_EMPTY   = 2'b00,
    DR_ALMOST_FULL = 2'b01,
    DR_EVENT       = 2'b10,
    DR_RESERVED    = 2'b11
  } dr_mode_e;

  localparam logic [WORD_W-1:0] NONVALID_WORD = 32'h0060_0000;

  function automatic logic is_eob(input logic [WORD_W-1:0] w);
    return w[KIND_HI:KIND_LO] == KIND_EOB;
  endfunction
endpackage

// File: rtl/hrb_store.sv
module hrb_store #(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 256,
  parameter int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              wr_eob,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic              head_eob
);
  logic [DATA_W-1:0] mem [DEPTH];
  logic [DEPTH-1:0]  eob_flag;

  // word storage: single write port, registered read port
  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
    if (rd_en) rd_data <= mem[rd_addr];
  end

  // one end-of-block marker per slot, read without latency
  for (genvar g = 0; g < DEPTH; g++) begin : g_flag
    always_ff @(posedge clk) begin
      if (wr_en && wr_addr == ADDR_W'(g)) eob_flag[g] <= wr_eob;
    end
  end

  assign head_eob = eob_flag[rd_addr];
endmodule

// File: rtl/hrb_ctrl.sv
module hrb_ctrl #(
  parameter int DEPTH  = 256,
  parameter int ADDR_W = $clog2(DEPTH),
  parameter int CNT_W  = ADDR_W + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              push,
  input  logic              push_eob,
  input  logic              pop,
  input  logic              head_eob,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_ptr,
  output logic              rd_en,
  output logic [ADDR_W-1:0] rd_ptr,
  output logic              empty_now,
  output logic [CNT_W-1:0]  cnt_next,
  output logic [CNT_W-1:0]  evt_next,
  output logic              full_q,
  output logic              ovf_q
);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

  logic [CNT_W-1:0] cnt_q, evt_q;
  logic             room, dec_evt, inc_evt;

  assign room      = cnt_q != FULL_CNT;
  assign empty_now = cnt_q == '0;
  assign wr_en     = push && room && !clr;
  assign rd_en     = pop && !empty_now && !clr;
  assign inc_evt   = wr_en && push_eob;
  assign dec_evt   = rd_en && head_eob;

  always_comb begin
    if (clr) begin
      cnt_next = '0;
      evt_next = '0;
    end else begin
      cnt_next = cnt_q + CNT_W'(wr_en) - CNT_W'(rd_en);
      evt_next = evt_q + CNT_W'(inc_evt) - CNT_W'(dec_evt);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      evt_q  <= '0;
      wr_ptr <= '0;
      rd_ptr <= '0;
      full_q <= 1'b0;
      ovf_q  <= 1'b0;
    end else begin
      cnt_q  <= cnt_next;
      evt_q  <= evt_next;
      full_q <= cnt_next == FULL_CNT;
      if (clr) begin
        wr_ptr <= '0;
        rd_ptr <= '0;
        ovf_q  <= 1'b0;
      end else begin
        if (wr_en) wr_ptr <= wr_ptr + 1'b1;
        if (rd_en) rd_ptr <= rd_ptr + 1'b1;
        if (push && !room) ovf_q <= 1'b1;
      end
    end
  end

  // R6
  empty_pop_stable_chk: assert property (@(posedge clk) disable iff (rst)
    (pop && empty_now && !push && !clr) |=> empty_now);
  // R8
  full_push_dropped_chk: assert property (@(posedge clk) disable iff (rst)
    (push && !room && !pop && !clr) |=> (!room && ovf_q));
  // R9
  clear_empties_chk: assert property (@(posedge clk) disable iff (rst)
    clr |=> (empty_now && evt_q == '0 && !ovf_q));
  // R4
  events_within_words_chk: assert property (@(posedge clk) disable iff (rst)
    evt_q <= cnt_q);
endmodule

// File: rtl/hrb_ready.sv
module hrb_ready
  import hrb_pkg::*;
#(
  parameter int CNT_W = 9
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [1:0]       mode,
  input  logic             cont,
  input  logic [CNT_W-1:0] af_level,
  input  logic [CNT_W-1:0] cnt_next,
  input  logic [CNT_W-1:0] evt_next,
  output logic             ready_q,
  output logic             bad_mode_q
);
  dr_mode_e m;
  logic     ready_d, bad_d;

  always_comb begin
    m       = dr_mode_e'(mode);
    ready_d = 1'b0;
    bad_d   = 1'b0;
    case (m)
      DR_NOT_EMPTY:   ready_d = cnt_next != '0;
      DR_ALMOST_FULL: ready_d = cnt_next >= af_level;
      DR_EVENT: begin
        bad_d   = cont;
        ready_d = !cont && (evt_next != '0);
      end
      default:        bad_d = 1'b1;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ready_q    <= 1'b0;
      bad_mode_q <= 1'b0;
    end else begin
      ready_q    <= ready_d;
      bad_mode_q <= bad_d;
    end
  end

  // R5
  no_ready_in_bad_mode_chk: assert property (@(posedge clk) disable iff (rst)
    !(ready_q && bad_mode_q));
endmodule

// File: rtl/hit_readout_buf.sv
module hit_readout_buf
  import hrb_pkg::*;
#(
  parameter int DEPTH  = 256,
  parameter int ADDR_W = $clog2(DEPTH),
  parameter int CNT_W  = ADDR_W + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr_all,
  input  logic              wr_valid,
  input  logic [31:0]       wr_word,
  input  logic              rd_strobe,
  output logic [31:0]       rd_word,
  input  logic [1:0]        ready_mode,
  input  logic [CNT_W-1:0]  af_level,
  input  logic              cont_mode,
  output logic              data_ready,
  output logic              buf_full,
  output logic              overflow_err,
  output logic              mode_err
);
  logic              wr_en, rd_en, head_eob, empty_now;
  logic [ADDR_W-1:0] wr_ptr, rd_ptr;
  logic [CNT_W-1:0]  cnt_next, evt_next;
  logic [31:0]       mem_q;
  logic              nonval_q;

  hrb_ctrl #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rst(rst), .clr(clr_all),
    .push(wr_valid), .push_eob(is_eob(wr_word)), .pop(rd_strobe),
    .head_eob(head_eob), .wr_en(wr_en), .wr_ptr(wr_ptr),
    .rd_en(rd_en), .rd_ptr(rd_ptr), .empty_now(empty_now),
    .cnt_next(cnt_next), .evt_next(evt_next),
    .full_q(buf_full), .ovf_q(overflow_err)
  );

  hrb_store #(.DATA_W(WORD_W), .DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_store (
    .clk(clk), .wr_en(wr_en), .wr_addr(wr_ptr), .wr_data(wr_word),
    .wr_eob(is_eob(wr_word)), .rd_en(rd_en), .rd_addr(rd_ptr),
    .rd_data(mem_q), .head_eob(head_eob)
  );

  hrb_ready #(.CNT_W(CNT_W)) u_ready (
    .clk(clk), .rst(rst), .mode(ready_mode), .cont(cont_mode),
    .af_level(af_level), .cnt_next(cnt_next), .evt_next(evt_next),
    .ready_q(data_ready), .bad_mode_q(mode_err)
  );

  // selects the non-valid word for reads of an empty store
  always_ff @(posedge clk) begin
    if (rst) nonval_q <= 1'b1;
    else if (rd_strobe && !clr_all) nonval_q <= empty_now;
  end

  assign rd_word = nonval_q ? NONVALID_WORD : mem_q;

  // R6
  empty_read_tag_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_strobe && empty_now && !clr_all) |=> rd_word == NONVALID_WORD);
  // R1
  real_read_untagged_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_strobe && !empty_now && !clr_all) |=> !nonval_q);
endmodule

// File: tb/hit_readout_buf_bench.sv
module hit_readout_buf_bench;
  localparam int DEPTH = 256;
  localparam int CNT_W = 9;
  localparam logic [31:0] NVD = 32'h0060_0000;

  logic clk = 1'b0;
  logic rst, clr_all, wr_valid, rd_strobe, cont_mode;
  logic [31:0] wr_word, rd_word;
  logic [1:0] ready_mode;
  logic [CNT_W-1:0] af_level;
  logic data_ready, buf_full, overflow_err, mode_err;
  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  hit_readout_buf #(.DEPTH(DEPTH)) u_hit_readout_buf (
    .clk(clk), .rst(rst), .clr_all(clr_all), .wr_valid(wr_valid),
    .wr_word(wr_word), .rd_strobe(rd_strobe), .rd_word(rd_word),
    .ready_mode(ready_mode), .af_level(af_level), .cont_mode(cont_mode),
    .data_ready(data_ready), .buf_full(buf_full),
    .overflow_err(overflow_err), .mode_err(mode_err)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic push(input logic [31:0] w);
    wr_valid = 1'b1; wr_word = w;
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  task automatic pop_expect(input logic [31:0] exp, input string req);
    rd_strobe = 1'b1;
    @(negedge clk);
    rd_strobe = 1'b0;
    check(req, rd_word, exp);
  endtask

  task automatic clear_all;
    clr_all = 1'b1;
    @(negedge clk);
    clr_all = 1'b0;
  endtask

  task automatic t_reset;
    check("R10 data_ready", {31'd0, data_ready}, 32'd0);
    check("R10 buf_full", {31'd0, buf_full}, 32'd0);
    check("R10 overflow_err", {31'd0, overflow_err}, 32'd0);
    check("R10 mode_err", {31'd0, mode_err}, 32'd0);
    check("R10 rd_word", rd_word, NVD);
  endtask

  task automatic t_not_empty_order;
    ready_mode = 2'b00;
    pop_expect(NVD, "R6 empty read");
    check("R2 empty read keeps empty", {31'd0, data_ready}, 32'd0);
    push(32'hA5A5_0001);
    check("R2 ready after first write", {31'd0, data_ready}, 32'd1);
    push(32'hFF9F_FFFF);
    push(32'h0000_0003);
    pop_expect(32'hA5A5_0001, "R1 first word");
    pop_expect(32'hFF9F_FFFF, "R1 second word all bits");
    check("R2 still ready with one word", {31'd0, data_ready}, 32'd1);
    pop_expect(32'h0000_0003, "R1 third word");
    check("R2 low after drain", {31'd0, data_ready}, 32'd0);
    pop_expect(NVD, "R6 read after drain");
  endtask

  task automatic t_almost_full;
    ready_mode = 2'b01; af_level = 9'd3;
    @(negedge clk);
    push(32'h1); push(32'h2);
    check("R3 below level", {31'd0, data_ready}, 32'd0);
    push(32'h3);
    check("R3 at level", {31'd0, data_ready}, 32'd1);
    pop_expect(32'h1, "R1 almost-full order");
    check("R3 back below level", {31'd0, data_ready}, 32'd0);
    clear_all;
  endtask

  task automatic t_event;
    ready_mode = 2'b10; cont_mode = 1'b0;
    @(negedge clk);
    push(32'h0040_0000); push(32'h0000_0011);
    check("R4 no complete event", {31'd0, data_ready}, 32'd0);
    push(32'h0020_0001);
    check("R4 one event", {31'd0, data_ready}, 32'd1);
    push(32'h0040_0001); push(32'h0000_0022); push(32'h0020_0001);
    pop_expect(32'h0040_0000, "R4 header read");
    pop_expect(32'h0000_0011, "R4 datum read");
    pop_expect(32'h0020_0001, "R4 eob read");
    check("R4 second event keeps ready", {31'd0, data_ready}, 32'd1);
    pop_expect(32'h0040_0001, "R4 header2 read");
    pop_expect(32'h0000_0022, "R4 datum2 read");
    check("R4 ready until eob read", {31'd0, data_ready}, 32'd1);
    pop_expect(32'h0020_0001, "R4 eob2 read");
    check("R4 low after last eob", {31'd0, data_ready}, 32'd0);
  endtask

  task automatic t_bad_mode;
    ready_mode = 2'b10; cont_mode = 1'b1;
    push(32'h0020_0005);
    check("R5 cont+event ready low", {31'd0, data_ready}, 32'd0);
    check("R5 cont+event mode_err", {31'd0, mode_err}, 32'd1);
    ready_mode = 2'b11; cont_mode = 1'b0;
    @(negedge clk);
    check("R5 reserved ready low", {31'd0, data_ready}, 32'd0);
    check("R5 reserved mode_err", {31'd0, mode_err}, 32'd1);
    ready_mode = 2'b10;
    @(negedge clk);
    check("R5 legal event mode_err", {31'd0, mode_err}, 32'd0);
    check("R4 stored eob seen", {31'd0, data_ready}, 32'd1);
  endtask

  task automatic t_clear;
    ready_mode = 2'b10;
    clear_all;
    check("R9 event count zeroed", {31'd0, data_ready}, 32'd0);
    push(32'h0040_0009);
    check("R9 header alone not ready", {31'd0, data_ready}, 32'd0);
    ready_mode = 2'b00;
    clr_all = 1'b1; wr_valid = 1'b1; wr_word = 32'h0000_0077;
    @(negedge clk);
    clr_all = 1'b0; wr_valid = 1'b0;
    check("R9 write with clear ignored", {31'd0, data_ready}, 32'd0);
    pop_expect(NVD, "R9 store empty after clear");
  endtask

  task automatic t_full;
    ready_mode = 2'b00;
    for (int i = 0; i < DEPTH; i++) push(32'(i));
    check("R7 full at depth", {31'd0, buf_full}, 32'd1);
    check("R8 no overflow yet", {31'd0, overflow_err}, 32'd0);
    push(32'h0000_BEEF);
    check("R8 overflow set", {31'd0, overflow_err}, 32'd1);
    check("R7 still full", {31'd0, buf_full}, 32'd1);
    wr_valid = 1'b1; wr_word = 32'h0000_1234; rd_strobe = 1'b1;
    @(negedge clk);
    wr_valid = 1'b0; rd_strobe = 1'b0;
    check("R8 read beside dropped write", rd_word, 32'd0);
    check("R7 not full after read", {31'd0, buf_full}, 32'd0);
    begin
      int bad = 0;
      for (int i = 1; i < DEPTH; i++) begin
        rd_strobe = 1'b1;
        @(negedge clk);
        rd_strobe = 1'b0;
        if (rd_word !== 32'(i)) begin
          bad++;
          if (bad == 1) check("R1 drain order", rd_word, 32'(i));
        end
      end
      if (bad == 0) check("R1 drain order", 32'd0, 32'd0);
    end
    pop_expect(NVD, "R8 dropped words not stored");
    check("R8 overflow sticky", {31'd0, overflow_err}, 32'd1);
    clear_all;
    check("R9 overflow cleared", {31'd0, overflow_err}, 32'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst = 1'b1; clr_all = 1'b0; wr_valid = 1'b0; rd_strobe = 1'b0;
    wr_word = '0; ready_mode = 2'b00; af_level = '0; cont_mode = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset;
    t_not_empty_order;
    t_almost_full;
    t_event;
    t_bad_mode;
    t_clear;
    t_full;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule